// File: doc/BRIEF.md
# Serial Scan Memory Test Controller

This block lets an external tester exercise a bank of sixteen on-chip memory macros through one 112-bit command register. The tester fills the register in one of two ways. It can shift the register in bit by bit through a serial pin, or it can load it in one step from a wide parallel word. A launch strobe then copies the register onto the memory buses for one cycle. Selectors 0 to 7 address dual-port macros on a two-port left bus. Selectors 8 to 15 address single-port macros on a one-port right bus.

When a port of the command performs a read, the data that the macro returns is written back into that port's data field. The updated register can then be shifted out serially, or read in parallel, and compared by the tester.

The memory macros are outside the block. Every read-data port of each macro comes back to the controller as a 32-bit lane. A narrower macro zero-extends its data. A single-port macro returns zero on its second lane.

Top module: `stt_scan_ctrl`

## Requirements
- R1: The command word layout is fixed.
  - Bits [111:108] hold the macro selector.
  - Bits [107:54] hold port 0 and bits [53:0] hold port 1.
  - Within a 54-bit port field, [53:38] is the address, [37:6] is the data, [5] is the active-low chip select, [4] is the active-low write enable, and [3:0] is the write mask.
  - On each clock edge with `src_serial`=1 and `scan_en`=1, the word shifts left by one and bit 0 takes `ser_in`.
  - `ser_out` always shows bit 111.
- R2: On an edge with `src_serial`=0 and `par_load`=1, the register takes `par_word`. `par_load` has no effect while `src_serial`=1, and `scan_en` does not shift while `src_serial`=0.
- R3: An edge with `scan_en`=0 and `mem_launch`=1 drives the register's command onto the buses during the following cycle. In any other cycle, every bus is idle: all chip selects 1, write enable 1, and address, data and mask 0.
- R4: For selector values 0 to 7, left port 0 carries the port 0 fields and left port 1 carries the port 1 fields. On each of these ports, chip-select bit [sel] equals the packet's chip-select bit and all other chip-select bits are 1. The write mask is passed through unchanged; bit i enables byte i.
- R5: For selector values 8 to 15, the right bus carries the port 0 fields, with chip-select bit [sel] taken from the packet. Port 1 fields reach no bus. If port 1 encodes a read, it captures the macro's second lane, which is zero for these macros.
- R6: The bus of the bank that is not selected stays idle. No chip-select vector ever has more than one bit low.
- R7: A port whose command at launch is a read (chip select 0, write enable 1) has its data field replaced on the second edge after the launch edge. The new value is the selected macro's returned lane for that port. Ports that write or stay idle keep their data.
- R8: Without a shift, a load or a capture, the register holds its value.
- R9: Reset clears the register and leaves all buses idle.
- R10: A capture takes precedence over a shift or a load that falls on the same edge. That shift or load is dropped for that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for register, buses and capture |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_serial | input | 1 | 1 selects the serial path, 0 the parallel path |
| scan_en | input | 1 | Shift enable for the serial path |
| ser_in | input | 1 | Serial data in |
| ser_out | output | 1 | Register MSB |
| par_load | input | 1 | Parallel load strobe |
| par_word | input | 112 | Parallel command word |
| word_out | output | 112 | Current register contents |
| mem_launch | input | 1 | Launch strobe (honoured only while scan_en is 0) |
| l0_addr | output | 16 | Left bus port 0 address |
| l0_wdata | output | 32 | Left bus port 0 write data |
| l0_we_n | output | 1 | Left bus port 0 write enable, active low |
| l0_mask | output | 4 | Left bus port 0 byte mask |
| l0_cs_n | output | 16 | Left bus port 0 chip selects, active low |
| l1_addr | output | 16 | Left bus port 1 address |
| l1_wdata | output | 32 | Left bus port 1 write data |
| l1_we_n | output | 1 | Left bus port 1 write enable, active low |
| l1_mask | output | 4 | Left bus port 1 byte mask |
| l1_cs_n | output | 16 | Left bus port 1 chip selects, active low |
| r_addr | output | 16 | Right bus address |
| r_wdata | output | 32 | Right bus write data |
| r_we_n | output | 1 | Right bus write enable, active low |
| r_mask | output | 4 | Right bus byte mask |
| r_cs_n | output | 16 | Right bus chip selects, active low |
| rd_data0 | input | 16x32 | First read lane of each macro |
| rd_data1 | input | 16x32 | Second read lane of each macro |

## Verification
The controller is exercised with the following command patterns:
- A masked write followed by a read on a left-bank macro, checking that the captured data comes from the right address and the right bytes.
- A mixed packet that reads on one port and writes on the other, showing that only the reading port's data field is replaced.
- A right-bank write and read, separating the right bus from the left bus and confirming that the second lane reads as zero.
- A read from the 8-bit macro, showing zero extension.
- A serial readback of a captured word, checking bit order.
- Strobes on the disabled path, which must leave the register untouched.
- A shift that overlaps a capture, which shows that the capture takes precedence on that edge.

// File: rtl/stt_pkg.sv
package stt_pkg;
    parameter int SEL_W  = 4;
    parameter int ADDR_W = 16;
    parameter int DATA_W = 32;
    parameter int MASK_W = 4;
    localparam int NUM_MACROS = 1 << SEL_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              cs_n;
        logic              we_n;
        logic [MASK_W-1:0] mask;
    } port_cmd_t;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        port_cmd_t        p0;
        port_cmd_t        p1;
    } cmd_word_t;

    localparam int WORD_W = $bits(cmd_word_t);

    typedef struct packed {
        logic [ADDR_W-1:0]     addr;
        logic [DATA_W-1:0]     wdata;
        logic                  we_n;
        logic [MASK_W-1:0]     mask;
        logic [NUM_MACROS-1:0] cs_n;
    } bus_t;

    localparam bus_t BUS_IDLE = '{addr: '0, wdata: '0, we_n: 1'b1,
                                  mask: '0, cs_n: '1};
endpackage

// File: rtl/stt_cmd_reg.sv
module stt_cmd_reg
    import stt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              ser_in,
    input  logic              load_en,
    input  cmd_word_t         load_word,
    input  logic [1:0]        cap_en,
    input  logic [DATA_W-1:0] cap_data0,
    input  logic [DATA_W-1:0] cap_data1,
    output cmd_word_t         word_q
);
    cmd_word_t word_d;

    // capture wins over shift and load on the same edge
    always_comb begin
        word_d = word_q;
        if (|cap_en) begin
            if (cap_en[0]) word_d.p0.data = cap_data0;
            if (cap_en[1]) word_d.p1.data = cap_data1;
        end else if (shift_en) begin
            word_d = cmd_word_t'({word_q[WORD_W-2:0], ser_in});
        end else if (load_en) begin
            word_d = load_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end
endmodule

// File: rtl/stt_port_drv.sv
module stt_port_drv
    import stt_pkg::*;
#(
    parameter logic BANK = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [SEL_W-1:0] sel,
    input  port_cmd_t        cmd,
    output bus_t             bus_q
);
    bus_t bus_d;

    always_comb begin
        bus_d = BUS_IDLE;
        if (launch && (sel[SEL_W-1] == BANK)) begin
            bus_d.addr       = cmd.addr;
            bus_d.wdata      = cmd.data;
            bus_d.we_n       = cmd.we_n;
            bus_d.mask       = cmd.mask;
            bus_d.cs_n[sel]  = cmd.cs_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_q <= BUS_IDLE;
        else        bus_q <= bus_d;
    end
endmodule

// File: rtl/stt_rd_track.sv
module stt_rd_track
    import stt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [SEL_W-1:0] sel,
    input  logic [1:0]       rd_req,
    output logic [1:0]       cap_en,
    output logic [SEL_W-1:0] cap_sel
);
    typedef struct packed {
        logic [1:0]       rd_a;
        logic [SEL_W-1:0] sel_a;
        logic [1:0]       rd_b;
        logic [SEL_W-1:0] sel_b;
    } trk_t;

    trk_t trk_d, trk_q;

    // stage a: access on the bus; stage b: macro data valid
    always_comb begin
        trk_d       = trk_q;
        trk_d.rd_a  = launch ? rd_req : 2'b00;
        trk_d.sel_a = launch ? sel : trk_q.sel_a;
        trk_d.rd_b  = trk_q.rd_a;
        trk_d.sel_b = trk_q.sel_a;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign cap_en  = trk_q.rd_b;
    assign cap_sel = trk_q.sel_b;
endmodule

// File: rtl/stt_scan_ctrl.sv
module stt_scan_ctrl
    import stt_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              src_serial,
    input  logic                              scan_en,
    input  logic                              ser_in,
    output logic                              ser_out,
    input  logic                              par_load,
    input  logic [WORD_W-1:0]                 par_word,
    output logic [WORD_W-1:0]                 word_out,
    input  logic                              mem_launch,
    output logic [ADDR_W-1:0]                 l0_addr,
    output logic [DATA_W-1:0]                 l0_wdata,
    output logic                              l0_we_n,
    output logic [MASK_W-1:0]                 l0_mask,
    output logic [NUM_MACROS-1:0]             l0_cs_n,
    output logic [ADDR_W-1:0]                 l1_addr,
    output logic [DATA_W-1:0]                 l1_wdata,
    output logic                              l1_we_n,
    output logic [MASK_W-1:0]                 l1_mask,
    output logic [NUM_MACROS-1:0]             l1_cs_n,
    output logic [ADDR_W-1:0]                 r_addr,
    output logic [DATA_W-1:0]                 r_wdata,
    output logic                              r_we_n,
    output logic [MASK_W-1:0]                 r_mask,
    output logic [NUM_MACROS-1:0]             r_cs_n,
    input  logic [NUM_MACROS-1:0][DATA_W-1:0] rd_data0,
    input  logic [NUM_MACROS-1:0][DATA_W-1:0] rd_data1
);
    localparam int NUM_LANES = 3;

    cmd_word_t        word_q;
    logic             shift_en, load_en, launch;
    logic [1:0]       cap_en, rd_req;
    logic [SEL_W-1:0] cap_sel;
    port_cmd_t        lane_cmd [NUM_LANES];
    bus_t             lane_bus [NUM_LANES];

    assign shift_en = src_serial && scan_en;
    assign load_en  = !src_serial && par_load;
    assign launch   = !scan_en && mem_launch;
    assign rd_req   = {!word_q.p1.cs_n && word_q.p1.we_n,
                       !word_q.p0.cs_n && word_q.p0.we_n};

    stt_cmd_reg u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .ser_in    (ser_in),
        .load_en   (load_en),
        .load_word (cmd_word_t'(par_word)),
        .cap_en    (cap_en),
        .cap_data0 (rd_data0[cap_sel]),
        .cap_data1 (rd_data1[cap_sel]),
        .word_q    (word_q)
    );

    stt_rd_track u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .sel     (word_q.sel),
        .rd_req  (rd_req),
        .cap_en  (cap_en),
        .cap_sel (cap_sel)
    );

    // lanes 0,1: left bank ports; lane 2: right bank, fed by port 0
    assign lane_cmd[0] = word_q.p0;
    assign lane_cmd[1] = word_q.p1;
    assign lane_cmd[2] = word_q.p0;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        stt_port_drv #(.BANK(g == NUM_LANES - 1)) u_drv (
            .clk    (clk),
            .rst_n  (rst_n),
            .launch (launch),
            .sel    (word_q.sel),
            .cmd    (lane_cmd[g]),
            .bus_q  (lane_bus[g])
        );
    end

    assign ser_out  = word_q[WORD_W-1];
    assign word_out = word_q;

    assign l0_addr  = lane_bus[0].addr;
    assign l0_wdata = lane_bus[0].wdata;
    assign l0_we_n  = lane_bus[0].we_n;
    assign l0_mask  = lane_bus[0].mask;
    assign l0_cs_n  = lane_bus[0].cs_n;
    assign l1_addr  = lane_bus[1].addr;
    assign l1_wdata = lane_bus[1].wdata;
    assign l1_we_n  = lane_bus[1].we_n;
    assign l1_mask  = lane_bus[1].mask;
    assign l1_cs_n  = lane_bus[1].cs_n;
    assign r_addr   = lane_bus[2].addr;
    assign r_wdata  = lane_bus[2].wdata;
    assign r_we_n   = lane_bus[2].we_n;
    assign r_mask   = lane_bus[2].mask;
    assign r_cs_n   = lane_bus[2].cs_n;
endmodule

// File: rtl/stt_scan_ctrl_chk.sv
module stt_scan_ctrl_chk
    import stt_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  src_serial,
    input logic                  scan_en,
    input logic                  ser_in,
    input logic                  par_load,
    input logic                  mem_launch,
    input logic [WORD_W-1:0]     word_out,
    input logic                  l0_we_n,
    input logic                  l1_we_n,
    input logic                  r_we_n,
    input logic [NUM_MACROS-1:0] l0_cs_n,
    input logic [NUM_MACROS-1:0] l1_cs_n,
    input logic [NUM_MACROS-1:0] r_cs_n,
    input logic [1:0]            cap_en
);
    logic left_busy, right_busy;
    assign left_busy  = !(&l0_cs_n) || !(&l1_cs_n);
    assign right_busy = !(&r_cs_n);

    a_r6_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~l0_cs_n) <= 1 && $countones(~l1_cs_n) <= 1
        && $countones(~r_cs_n) <= 1);

    a_r6_bank_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(left_busy && right_busy));

    a_r3_idle_without_launch: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(!scan_en && mem_launch)
        |-> (!left_busy && !right_busy && l0_we_n && l1_we_n && r_we_n));

    a_r1_shift_in_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && src_serial && scan_en && cap_en == 2'b00)
        |-> word_out[0] == $past(ser_in));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && cap_en == 2'b00 && !(src_serial && scan_en)
              && !(!src_serial && par_load))
        |-> $stable(word_out));

    a_r10_capture_first: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && cap_en != 2'b00)
        |-> word_out[WORD_W-1 -: 16] == $past(word_out[WORD_W-1 -: 16]));
endmodule

bind stt_scan_ctrl stt_scan_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_serial (src_serial),
    .scan_en    (scan_en),
    .ser_in     (ser_in),
    .par_load   (par_load),
    .mem_launch (mem_launch),
    .word_out   (word_out),
    .l0_we_n    (l0_we_n),
    .l1_we_n    (l1_we_n),
    .r_we_n     (r_we_n),
    .l0_cs_n    (l0_cs_n),
    .l1_cs_n    (l1_cs_n),
    .r_cs_n     (r_cs_n),
    .cap_en     (cap_en)
);

// File: tb/stt_scan_ctrl_tb.sv
module stt_scan_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic src_serial = 1'b1, scan_en = 1'b0, ser_in = 1'b0;
    logic par_load = 1'b0, mem_launch = 1'b0;
    logic [111:0] par_word = '0;
    logic ser_out;
    logic [111:0] word_out;
    logic [15:0] l0_addr, l1_addr, r_addr;
    logic [31:0] l0_wdata, l1_wdata, r_wdata;
    logic l0_we_n, l1_we_n, r_we_n;
    logic [3:0] l0_mask, l1_mask, r_mask;
    logic [15:0] l0_cs_n, l1_cs_n, r_cs_n;
    logic [15:0][31:0] rd0_q = '0, rd1_q = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stt_scan_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_serial(src_serial), .scan_en(scan_en),
        .ser_in(ser_in), .ser_out(ser_out), .par_load(par_load),
        .par_word(par_word), .word_out(word_out), .mem_launch(mem_launch),
        .l0_addr(l0_addr), .l0_wdata(l0_wdata), .l0_we_n(l0_we_n),
        .l0_mask(l0_mask), .l0_cs_n(l0_cs_n),
        .l1_addr(l1_addr), .l1_wdata(l1_wdata), .l1_we_n(l1_we_n),
        .l1_mask(l1_mask), .l1_cs_n(l1_cs_n),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_we_n(r_we_n),
        .r_mask(r_mask), .r_cs_n(r_cs_n),
        .rd_data0(rd0_q), .rd_data1(rd1_q)
    );

    int vectors = 0, miscompares = 0;
    string cur_req = "R9";
    bit started = 0, done = 0;

    task automatic chk(string tag, string what, logic [111:0] act, logic [111:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural memory bank ----------------
    logic [31:0] mem [16][64];
    initial for (int m = 0; m < 16; m++) for (int a = 0; a < 64; a++) mem[m][a] = '0;

    task automatic mem_port(int m, bit p, logic [15:0] a, logic [31:0] wd,
                            logic we_n, logic [3:0] mk);
        if (!we_n) begin
            for (int b = 0; b < 4; b++)
                if (mk[b] && (m != 0 || b == 0)) mem[m][a[5:0]][8*b +: 8] <= wd[8*b +: 8];
        end else begin
            logic [31:0] v;
            v = (m == 0) ? {24'h0, mem[m][a[5:0]][7:0]} : mem[m][a[5:0]];
            if (p) rd1_q[m] <= v; else rd0_q[m] <= v;
        end
    endtask

    // ---------------- reference model ----------------
    logic [111:0] m_word = '0;
    logic [68:0]  e_bus [3];
    logic [1:0]   m_rd1 = '0, m_rd2 = '0;
    int           m_sel1 = 0, m_sel2 = 0;
    localparam logic [68:0] IDLE = {16'h0, 32'h0, 1'b1, 4'h0, 16'hFFFF};

    function automatic logic [68:0] lane_of(logic [53:0] pw, int sel);
        logic [15:0] cs;
        cs = 16'hFFFF;
        cs[sel] = pw[5];
        return {pw[53:38], pw[37:6], pw[4], pw[3:0], cs};
    endfunction

    always @(posedge clk) begin
        started <= 1;
        if (!rst_n) begin
            m_word = '0; m_rd1 = '0; m_rd2 = '0;
            for (int l = 0; l < 3; l++) e_bus[l] = IDLE;
        end else begin
            bit go;
            int s;
            logic [53:0] p0, p1;
            go = !scan_en && mem_launch;
            s  = int'(m_word[111:108]);
            p0 = m_word[107:54];
            p1 = m_word[53:0];
            for (int l = 0; l < 3; l++) e_bus[l] = IDLE;
            if (go) begin
                if (s < 8) begin e_bus[0] = lane_of(p0, s); e_bus[1] = lane_of(p1, s); end
                else e_bus[2] = lane_of(p0, s);
            end
            if (m_rd2 != 0) begin
                if (m_rd2[0]) m_word[91:60] = rd0_q[m_sel2];
                if (m_rd2[1]) m_word[37:6]  = rd1_q[m_sel2];
            end else if (src_serial && scan_en) m_word = {m_word[110:0], ser_in};
            else if (!src_serial && par_load) m_word = par_word;
            m_rd2 = m_rd1; m_sel2 = m_sel1;
            m_rd1 = go ? {!p1[5] && p1[4], !p0[5] && p0[4]} : 2'b00;
            if (go) m_sel1 = s;
        end
        for (int m = 0; m < 16; m++) begin
            if (m < 8) begin
                if (!l0_cs_n[m]) mem_port(m, 0, l0_addr, l0_wdata, l0_we_n, l0_mask);
                if (!l1_cs_n[m]) mem_port(m, 1, l1_addr, l1_wdata, l1_we_n, l1_mask);
            end else begin
                if (!r_cs_n[m]) mem_port(m, 0, r_addr, r_wdata, r_we_n, r_mask);
                rd1_q[m] <= '0;
            end
        end
    end

    always @(negedge clk) if (started && !done) begin
        chk(cur_req, "word", word_out, m_word);
        chk(cur_req, "ser_out", ser_out, m_word[111]);
        chk(cur_req, "left0", {l0_addr, l0_wdata, l0_we_n, l0_mask, l0_cs_n}, e_bus[0]);
        chk(cur_req, "left1", {l1_addr, l1_wdata, l1_we_n, l1_mask, l1_cs_n}, e_bus[1]);
        chk(cur_req, "right", {r_addr, r_wdata, r_we_n, r_mask, r_cs_n}, e_bus[2]);
    end

    // ---------------- stimulus ----------------
    function automatic logic [111:0] mk(logic [3:0] s,
        logic [15:0] a0, logic [31:0] d0, logic c0, logic w0, logic [3:0] k0,
        logic [15:0] a1, logic [31:0] d1, logic c1, logic w1, logic [3:0] k1);
        return {s, a0, d0, c0, w0, k0, a1, d1, c1, w1, k1};
    endfunction

    task automatic shift_io(logic [111:0] w, output logic [111:0] got);
        src_serial = 1; scan_en = 1;
        for (int j = 0; j < 112; j++) begin
            got[111-j] = ser_out;
            ser_in = w[111-j];
            @(negedge clk);
        end
        scan_en = 0; ser_in = 0;
    endtask

    task automatic par_put(logic [111:0] w);
        src_serial = 0; par_word = w; par_load = 1;
        @(negedge clk);
        par_load = 0; src_serial = 1;
    endtask

    task automatic fire();
        scan_en = 0; mem_launch = 1;
        @(negedge clk);
        mem_launch = 0;
    endtask

    logic [111:0] junk, got, snap, expw;

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R9";
        chk("R9", "reset word", word_out, '0);
        chk("R9", "reset cs", {l0_cs_n, l1_cs_n, r_cs_n}, {48{1'b1}});
        rst_n = 1;
        @(negedge clk);

        // R1/R4: serial write, macro 3, full mask
        cur_req = "R4";
        shift_io(mk(3, 5, 32'hA5A5_1234, 0, 0, 4'hF, 0, 0, 1, 1, 0), junk);
        fire();
        chk("R4", "l0 cs", l0_cs_n, 16'hFFF7);
        chk("R4", "l0 we", l0_we_n, 1'b0);
        chk("R4", "l0 mask", l0_mask, 4'hF);
        chk("R6", "right idle", r_cs_n, 16'hFFFF);
        @(negedge clk);
        cur_req = "R3";
        chk("R3", "idle after strobe", {l0_cs_n, l0_we_n}, {16'hFFFF, 1'b1});
        repeat (3) @(negedge clk);

        // R2/R7: parallel load, read port0, partial write port1
        cur_req = "R7";
        par_put(mk(3, 5, 0, 0, 1, 0, 9, 32'h1111_2222, 0, 0, 4'b0011));
        fire();
        repeat (3) @(negedge clk);
        chk("R7", "p0 captured", word_out[91:60], 32'hA5A5_1234);
        chk("R7", "p1 write kept", word_out[37:6], 32'h1111_2222);

        // R7 both ports read, then R1 serial readback
        par_put(mk(3, 9, 0, 0, 1, 0, 5, 0, 0, 1, 0));
        fire();
        repeat (3) @(negedge clk);
        cur_req = "R1";
        shift_io('0, got);
        chk("R1", "readback", got, mk(3, 9, 32'h0000_2222, 0, 1, 0, 5, 32'hA5A5_1234, 0, 1, 0));

        // R5/R6: right bank
        cur_req = "R5";
        shift_io(mk(10, 7, 32'hDEAD_BEEF, 0, 0, 4'hF, 7, 0, 0, 1, 0), junk);
        fire();
        chk("R5", "r cs", r_cs_n, 16'hFBFF);
        chk("R6", "left idle", {l0_cs_n, l1_cs_n}, 32'hFFFF_FFFF);
        repeat (3) @(negedge clk);
        shift_io(mk(10, 7, 0, 0, 1, 0, 0, 32'h55, 0, 1, 0), junk);
        fire();
        repeat (3) @(negedge clk);
        chk("R7", "right read", word_out[91:60], 32'hDEAD_BEEF);
        chk("R5", "second lane zero", word_out[37:6], 32'h0);

        // narrow macro 0 zero-extends
        cur_req = "R7";
        par_put(mk(0, 2, 32'h1234_5678, 0, 0, 4'hF, 0, 0, 1, 1, 0));
        fire(); repeat (3) @(negedge clk);
        par_put(mk(0, 2, 32'hFFFF_FFFF, 0, 1, 0, 0, 0, 1, 1, 0));
        fire(); repeat (3) @(negedge clk);
        chk("R7", "narrow read", word_out[91:60], 32'h0000_0078);

        // R2: strobes on the disabled path
        cur_req = "R2";
        snap = word_out;
        src_serial = 1; par_word = '1; par_load = 1;
        repeat (3) @(negedge clk);
        par_load = 0;
        chk("R2", "par ignored", word_out, snap);
        src_serial = 0; scan_en = 1; ser_in = 1;
        repeat (3) @(negedge clk);
        scan_en = 0; ser_in = 0; src_serial = 1;
        chk("R2", "scan ignored", word_out, snap);

        // R8 hold
        cur_req = "R8";
        repeat (5) @(negedge clk);
        chk("R8", "hold", word_out, snap);

        // R10 capture overlapping shift
        cur_req = "R10";
        snap = mk(3, 5, 32'h0, 0, 1, 0, 0, 0, 1, 1, 0);
        par_put(snap);
        fire();
        src_serial = 1; scan_en = 1; ser_in = 1;
        repeat (3) @(negedge clk);
        scan_en = 0; ser_in = 0;
        expw = {snap[110:0], 1'b1};
        expw[91:60] = 32'hA5A5_1234;
        expw = {expw[110:0], 1'b1};
        chk("R10", "capture first", word_out, expw);
        repeat (4) @(negedge clk);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            miscompares++;
            $display("FAIL R1-watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule